// File: doc/BRIEF.md
# Trace Exception Condition Classifier

This block sits beside a processor's retirement port and looks at one retirement block per cycle. Each block carries a valid strobe, a kind code, the number of 16-bit units retired, the start address of the block and a flag giving the size of its final instruction. When the kind code marks an exception or an interrupt, the block decides which of two trace conditions applies. The first is a trap with nothing retired alongside it. The second is a trap reported in the same block as a group of retired instructions.

A trace encoder must report the address of the last instruction that retired before every trap, and the source of that address depends on the condition. For a trap with retirements, the address is the final instruction of the current block, computed from the block's start, its unit count and the size of its tail instruction. For a lone trap, the address comes from the most recent block that retired anything. That address is kept in a register guarded by a two-state tracker. The tracker starts in EMPTY. The transition FIRST_RETIRE moves it to HELD on the first valid block with a non-zero count. It then stays in HELD, taking a fresh address on each such block, until reset returns it to EMPTY. A lone trap seen while the tracker is in EMPTY raises a separate no-address flag.

All outputs are registered and last exactly one cycle. The condition register steps through NONE, ALONE and WITH_RET each cycle, chosen from the inputs just sampled.

Top module: `trc_exc_classifier`

## Requirements
- R1: Kind code 0 marks a retire-only block, 1 an exception and 2 an interrupt. Code 3 is reserved and behaves like code 0: it raises no condition flag.
- R2: `exc_alone` rises when a valid block has kind 1 or 2 and a unit count of zero.
- R3: `exc_with_ret` rises when a valid block has kind 1 or 2 and a non-zero unit count. `exc_alone` and `exc_with_ret` are never high together.
- R4: A block's last-instruction address is `base + 2*units - (tail_wide ? 4 : 2)`, taken modulo 2^ADDR_W.
- R5: With `exc_with_ret`, `pre_addr` equals the last-instruction address of that same block.
- R6: With `exc_alone`, `pre_addr` equals the last-instruction address of the most recent earlier valid block that had a non-zero count, whatever that block's kind.
- R7: The saved address is replaced on every valid block with a non-zero count. It is held unchanged across zero-count blocks and cycles with `blk_valid` low.
- R8: Outputs are registered. Flags and `pre_addr` appear in the cycle after the block is sampled and stay for exactly that one cycle.
- R9: A lone trap that arrives before any retiring block since reset raises `pre_addr_none` together with `exc_alone`, and `pre_addr` reads 0. `pre_addr_none` is never high without `exc_alone`.
- R10: A cycle whose sampled `blk_valid` was low, or whose block carried no trap, drives all four outputs to 0.
- R11: While `rst_n` is low, all outputs are 0 and the saved address is discarded, which sends the tracker back to EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Retirement block present this cycle |
| blk_kind | input | 2 | Block kind code (0 retire, 1 exception, 2 interrupt, 3 reserved) |
| blk_units | input | CNT_W | Retired 16-bit units in the block |
| blk_base | input | ADDR_W | Address of the first instruction in the block |
| blk_tail_wide | input | 1 | 1 when the final instruction is 4 bytes, 0 when it is 2 bytes |
| exc_alone | output | 1 | Trap with no retirement in the same block |
| exc_with_ret | output | 1 | Trap in the same block as retirements |
| pre_addr | output | ADDR_W | Address of the last instruction retired before the trap |
| pre_addr_none | output | 1 | Lone trap seen before any retirement since reset |

## Verification
Two updates can land on the same clock edge. The saved-address register can take a new value while the output stage is choosing between that register and the address computed from the current block. A trap block with a non-zero count triggers both at once. The bench provokes this by sweeping every kind, count and tail size, so many trap-with-retirement blocks are followed directly by lone traps. A correct design reports the current block's address for the first and, on the next cycle, that same address for the lone trap, never the value saved before it. A reference model in the bench computes each expected address from R4 and tracks the saved address separately, so a block that mixes up the two sources shows up as an address mismatch.

// File: rtl/trc_exc_pkg.sv
package trc_exc_pkg;

    typedef enum logic [1:0] {
        KIND_RETIRE = 2'd0,
        KIND_EXC    = 2'd1,
        KIND_IRQ    = 2'd2,
        KIND_RSVD   = 2'd3
    } blk_kind_t;

    typedef enum logic {
        TRK_EMPTY = 1'b0,
        TRK_HELD  = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        COND_NONE     = 2'd0,
        COND_ALONE    = 2'd1,
        COND_WITH_RET = 2'd2
    } cond_t;

    function automatic logic is_trap_kind(input logic [1:0] kind);
        return (kind == KIND_EXC) || (kind == KIND_IRQ);
    endfunction

endpackage

// File: rtl/trc_last_addr.sv
module trc_last_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  units,
    input  logic              tail_wide,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int SPAN_W = CNT_W + 1;

    logic [SPAN_W-1:0] span_bytes;
    logic [ADDR_W-1:0] span_ext;
    logic [ADDR_W-1:0] tail_bytes;

    always_comb begin
        span_bytes = {units, 1'b0};
        span_ext   = ADDR_W'(span_bytes);
        tail_bytes = tail_wide ? ADDR_W'(4) : ADDR_W'(2);
        last_addr  = base + span_ext - tail_bytes;
    end

endmodule

// File: rtl/trc_addr_tracker.sv
module trc_addr_tracker
    import trc_exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] new_addr,
    output logic              held_valid,
    output logic [ADDR_W-1:0] held_addr
);
    trk_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_EMPTY: if (upd) state_d = TRK_HELD;   // FIRST_RETIRE
            TRK_HELD:  state_d = TRK_HELD;            // stays until reset
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
        end else if (upd) begin
            held_addr <= new_addr;
        end
    end

    assign held_valid = (state_q == TRK_HELD);

    p_held_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        held_valid |=> held_valid);

    p_update_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (held_valid && held_addr == $past(new_addr)));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && held_valid) |=> $stable(held_addr));

endmodule

// File: rtl/trc_exc_classify.sv
module trc_exc_classify
    import trc_exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic              count_nz,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              held_valid,
    input  logic [ADDR_W-1:0] held_addr,
    output logic              exc_alone,
    output logic              exc_with_ret,
    output logic [ADDR_W-1:0] pre_addr,
    output logic              pre_addr_none
);
    cond_t cond_d;

    always_comb begin
        cond_d = COND_NONE;
        if (in_valid && is_trap_kind(in_kind)) begin
            cond_d = count_nz ? COND_WITH_RET : COND_ALONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_alone     <= 1'b0;
            exc_with_ret  <= 1'b0;
            pre_addr      <= '0;
            pre_addr_none <= 1'b0;
        end else begin
            unique case (cond_d)
                COND_ALONE: begin
                    exc_alone     <= 1'b1;
                    exc_with_ret  <= 1'b0;
                    pre_addr      <= held_valid ? held_addr : '0;
                    pre_addr_none <= !held_valid;
                end
                COND_WITH_RET: begin
                    exc_alone     <= 1'b0;
                    exc_with_ret  <= 1'b1;
                    pre_addr      <= cur_addr;
                    pre_addr_none <= 1'b0;
                end
                default: begin
                    exc_alone     <= 1'b0;
                    exc_with_ret  <= 1'b0;
                    pre_addr      <= '0;
                    pre_addr_none <= 1'b0;
                end
            endcase
        end
    end

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_alone && exc_with_ret));

    p_none_needs_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_addr_none |-> exc_alone);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!exc_alone && !exc_with_ret && !pre_addr_none && pre_addr == '0));

    p_alone_raised_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_trap_kind(in_kind) && !count_nz) |=> exc_alone);

    p_with_ret_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_trap_kind(in_kind) && count_nz) |=> (exc_with_ret && pre_addr == $past(cur_addr)));

    p_alone_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_trap_kind(in_kind) && !count_nz && held_valid) |=> (pre_addr == $past(held_addr)));

endmodule

// File: rtl/trc_exc_classifier.sv
module trc_exc_classifier
    import trc_exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [1:0]        blk_kind,
    input  logic [CNT_W-1:0]  blk_units,
    input  logic [ADDR_W-1:0] blk_base,
    input  logic              blk_tail_wide,
    output logic              exc_alone,
    output logic              exc_with_ret,
    output logic [ADDR_W-1:0] pre_addr,
    output logic              pre_addr_none
);
    logic              units_nz;
    logic              take_addr;
    logic [ADDR_W-1:0] cur_last;
    logic              held_valid;
    logic [ADDR_W-1:0] held_addr;

    assign units_nz  = (blk_units != '0);
    assign take_addr = blk_valid && units_nz;

    trc_last_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_last (
        .base      (blk_base),
        .units     (blk_units),
        .tail_wide (blk_tail_wide),
        .last_addr (cur_last)
    );

    trc_addr_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (take_addr),
        .new_addr   (cur_last),
        .held_valid (held_valid),
        .held_addr  (held_addr)
    );

    trc_exc_classify #(.ADDR_W(ADDR_W)) u_cls (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (blk_valid),
        .in_kind       (blk_kind),
        .count_nz      (units_nz),
        .cur_addr      (cur_last),
        .held_valid    (held_valid),
        .held_addr     (held_addr),
        .exc_alone     (exc_alone),
        .exc_with_ret  (exc_with_ret),
        .pre_addr      (pre_addr),
        .pre_addr_none (pre_addr_none)
    );

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_alone && !blk_valid) |=> !exc_alone);

    p_reserved_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && (blk_kind == 2'd0 || blk_kind == 2'd3)) |=> (!exc_alone && !exc_with_ret));

endmodule

// File: tb/trc_exc_classifier_test.sv
`timescale 1ns/1ps
module trc_exc_classifier_test;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_valid = 1'b0;
    logic [1:0]        blk_kind = 2'd0;
    logic [CNT_W-1:0]  blk_units = '0;
    logic [ADDR_W-1:0] blk_base = '0;
    logic              blk_tail_wide = 1'b0;
    logic              exc_alone;
    logic              exc_with_ret;
    logic [ADDR_W-1:0] pre_addr;
    logic              pre_addr_none;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic              m_valid = 1'b0;
    logic [ADDR_W-1:0] m_addr  = '0;

    always #2.5 clk = ~clk;

    trc_exc_classifier #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_kind(blk_kind),
        .blk_units(blk_units), .blk_base(blk_base), .blk_tail_wide(blk_tail_wide),
        .exc_alone(exc_alone), .exc_with_ret(exc_with_ret),
        .pre_addr(pre_addr), .pre_addr_none(pre_addr_none)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] last_of(input logic [ADDR_W-1:0] b,
                                                  input int u, input bit w);
        return b + ADDR_W'(2 * u) - (w ? ADDR_W'(4) : ADDR_W'(2));
    endfunction

    // Drive at negedge, check one cycle later (R8), then return at negedge.
    task automatic step(input bit v, input int k, input int u,
                        input logic [ADDR_W-1:0] b, input bit w);
        bit trap, e_alone, e_ret, e_none;
        logic [ADDR_W-1:0] e_addr, cur;
        blk_valid = v; blk_kind = 2'(k); blk_units = CNT_W'(u);
        blk_base = b; blk_tail_wide = w;
        trap    = (k == 1) || (k == 2);                 // R1
        cur     = last_of(b, u, w);                     // R4
        e_alone = v && trap && (u == 0);                // R2
        e_ret   = v && trap && (u != 0);                // R3
        e_none  = e_alone && !m_valid;                  // R9
        e_addr  = e_ret ? cur : ((e_alone && m_valid) ? m_addr : '0); // R5 R6 R10
        @(posedge clk);
        if (v && u != 0) begin m_valid = 1'b1; m_addr = cur; end   // R7
        #1;
        chk("R2 exc_alone", 64'(exc_alone), 64'(e_alone));
        chk("R3 exc_with_ret", 64'(exc_with_ret), 64'(e_ret));
        chk(e_ret ? "R5 pre_addr" : (e_alone ? "R6 pre_addr" : "R10 pre_addr"),
            64'(pre_addr), 64'(e_addr));
        chk("R9 pre_addr_none", 64'(pre_addr_none), 64'(e_none));
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; blk_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset exc_alone", 64'(exc_alone), 64'd0);
        chk("R11 reset exc_with_ret", 64'(exc_with_ret), 64'd0);
        chk("R11 reset pre_addr", 64'(pre_addr), 64'd0);
        chk("R11 reset pre_addr_none", 64'(pre_addr_none), 64'd0);
        m_valid = 1'b0; m_addr = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] bases [3];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_0000;
        bases[2] = 32'hFFFF_FFF0;
        @(negedge clk);
        do_reset();

        // R9: lone trap before any retirement, both kinds
        step(1, 1, 0, 32'h40, 0);
        step(1, 2, 0, 32'h40, 1);
        // R1: reserved and retire-only kinds raise nothing
        step(1, 3, 0, 32'h80, 0);
        step(1, 0, 0, 32'h80, 0);
        // R7: first retirement, then hold across idle and zero-count blocks
        step(1, 0, 5, 32'h2000, 1);
        step(0, 1, 0, 32'h9999, 0);
        step(0, 0, 7, 32'h5550, 0);
        step(1, 3, 0, 32'h7770, 1);
        step(1, 1, 0, 32'h1234, 0);   // R6: address of the 0x2000 block
        // R8: trap then idle: flag lasts one cycle
        step(1, 2, 3, 32'h3000, 0);
        step(0, 0, 0, 32'h0, 0);

        // Sweep: every kind, count, tail size, valid, several bases (R4 wrap)
        for (int bi = 0; bi < 3; bi++)
            for (int v = 1; v >= 0; v--)
                for (int k = 0; k < 4; k++)
                    for (int u = 0; u < (1 << CNT_W); u++)
                        for (int w = 0; w < 2; w++) begin
                            step(v[0], k, u, bases[bi] + ADDR_W'(u * 16), w[0]);
                            step(1, 1 + (u % 2), 0, 32'hABC0, 0); // lone trap right after
                        end

        // R11: reset drops saved address; next lone trap has none (R9)
        step(1, 0, 4, 32'h6000, 0);
        do_reset();
        step(1, 1, 0, 32'h6000, 0);
        step(1, 2, 2, 32'h8000, 1);
        step(1, 1, 0, 32'h0, 0);

        finish_run();
    end

endmodule